// File: doc/BRIEF.md
# Cache Maintenance Command Queue Front End

This block sits between a software-visible register port and the engine that carries out maintenance on a cache. Software writes a mode word that names the operation, its scope and its target, and then, as the mode requires, a start address, a byte count and a mask of cache ways. The write that completes the required operands places the command in a small in-order queue. A set-status register then tells software whether that command was taken or whether it must write the whole command again. A separate queue-status register reports a sticky completion flag, a sticky error flag and a busy indication. Software clears the two sticky flags by writing ones to them.

The executor side is a valid/ready handshake that presents one command at a time. A done pulse, with an optional error qualifier, closes the command in flight. A second, independent channel carries single primitive operations and the buffer-drain request. A read of that channel's register is held off until the pending primitive has been retired, so software can use the read as a barrier.

Top module: `cmq_regfront`

## Requirements
- R1: After reset every register reads zero, the queue is empty, `ex_valid` and `prim_valid` are low, and reads of the unused word offset 7 return zero.
- R2: Word offsets are 0 mode, 1 start address, 2 byte size, 3 way mask, 4 set status (read only), 5 queue status and 6 primitive entry. Reads return data with `rd_ack` one clock after `rd_en`, except as stated in R11.
- R3: Mode word fields are operation [2:0], an extra control bit [14], a notify request [15], scope [18:17] (0 range, 1 whole cache, 2 selected ways, 3 reserved) and target [22:21] (value 2 means way-directed). Each field appears unchanged on the matching executor output.
- R4: For range scope without way-directed target, the command is queued on the size write, and it carries the written size and the stored start address. For whole-cache scope without way-directed target, the command is queued on the mode write itself.
- R5: When the scope is selected-ways or the target is way-directed, the command is queued on the way-mask write and carries that mask.
- R6: A mode write with reserved scope 3, or a range command whose size is zero at its queueing write, sets the fail flag (set status bit 1) and queues nothing.
- R7: The queue holds DEPTH commands and releases them oldest first. A command that would queue while DEPTH commands wait sets the overflow flag (set status bit 0) and is dropped.
- R8: Every mode write clears both set-status flags. Once a command has been queued or rejected, further operand writes queue nothing until the next mode write.
- R9: Only one command is in flight. After an accepted handshake, `ex_valid` stays low until `ex_done`. Queue status bit 0 is 1 while a command waits or is in flight.
- R10: `ex_done` for an in-flight command that asked for notification sets the end flag (queue status bit 2). A command without notification leaves that flag unchanged. Writing 1 to bit 2 clears the flag, and writing 0 leaves it unchanged.
- R11: `ex_done` together with `ex_err` sets the error flag (queue status bit 1), which is cleared by writing 1 to bit 1. A write of 0, 1, 2, 8 or 9 to the primitive entry while it is idle raises `prim_valid` with that code until `prim_done`. Other codes, and any write while it is busy, are ignored. A read of the primitive entry is not acknowledged while a primitive is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rd_ack |
| rd_ack | output | 1 | Read data valid pulse |
| ex_valid | output | 1 | Command offered to executor |
| ex_ready | input | 1 | Executor takes the command |
| ex_op | output | 3 | Operation code |
| ex_scope | output | 2 | Scope code |
| ex_tid | output | 2 | Target code |
| ex_notify | output | 1 | Notification request |
| ex_ctl | output | 1 | Extra control bit |
| ex_addr | output | 32 | Start address |
| ex_size | output | 32 | Byte size |
| ex_ways | output | NWAY | Way mask |
| ex_done | input | 1 | In-flight command finished |
| ex_err | input | 1 | Finished command had an error |
| prim_valid | output | 1 | Primitive pending |
| prim_code | output | 4 | Primitive code |
| prim_done | input | 1 | Primitive retired |

## Verification
A table of commands is driven through the same fixed sequence of mode, start, size and way writes. In that sequence, range, whole-cache, selected-way, way-directed range, reserved-scope and zero-size commands each queue at a different write or are rejected. This shows which write completes each operand set, and it shows that the extra operand writes after the queueing point add nothing. Directed tests then fill the queue past its depth and drain it, so overflow is told apart from ordering. They combine done with error and notify and clear the flags one at a time. They also hold a primitive pending while its register is read, to separate a stalled read from a plain one.

// File: rtl/cmq_regfront.sv
module cmq_regfront #(
  parameter int DEPTH = 4,
  parameter int NWAY  = 8,
  parameter int AW    = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic            rd_ack,
  output logic            ex_valid,
  input  logic            ex_ready,
  output logic [2:0]      ex_op,
  output logic [1:0]      ex_scope,
  output logic [1:0]      ex_tid,
  output logic            ex_notify,
  output logic            ex_ctl,
  output logic [31:0]     ex_addr,
  output logic [31:0]     ex_size,
  output logic [NWAY-1:0] ex_ways,
  input  logic            ex_done,
  input  logic            ex_err,
  output logic            prim_valid,
  output logic [3:0]      prim_code,
  input  logic            prim_done
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam int EW = 9 + 64 + NWAY;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  localparam logic [AW-1:0] A_MODE  = AW'(0);
  localparam logic [AW-1:0] A_START = AW'(1);
  localparam logic [AW-1:0] A_SIZE  = AW'(2);
  localparam logic [AW-1:0] A_WAYS  = AW'(3);
  localparam logic [AW-1:0] A_SETST = AW'(4);
  localparam logic [AW-1:0] A_QSTAT = AW'(5);
  localparam logic [AW-1:0] A_PRIM  = AW'(6);

  logic [31:0]     mode_q, start_q, size_q;
  logic [NWAY-1:0] ways_q;
  logic            armed_q;
  logic            fail_f, ovf_f, end_f, err_f;
  logic            fly, fly_notify;
  logic [EW-1:0]   mem [DEPTH];
  logic [PW-1:0]   wp, rp;
  logic [CW-1:0]   cnt;
  logic            prim_busy;
  logic [3:0]      pcode_q;
  logic            rd_hold;
  logic [AW-1:0]   rd_sel;

  logic wr_mode, wr_start, wr_size, wr_ways, wr_qstat, wr_prim;
  assign wr_mode  = wr_en && addr == A_MODE;
  assign wr_start = wr_en && addr == A_START;
  assign wr_size  = wr_en && addr == A_SIZE;
  assign wr_ways  = wr_en && addr == A_WAYS;
  assign wr_qstat = wr_en && addr == A_QSTAT;
  assign wr_prim  = wr_en && addr == A_PRIM;

  logic [31:0]     mode_n, start_n, size_n;
  logic [NWAY-1:0] ways_n;
  assign mode_n  = wr_mode  ? wdata : mode_q;
  assign start_n = wr_start ? wdata : start_q;
  assign size_n  = wr_size  ? wdata : size_q;
  assign ways_n  = wr_ways  ? wdata[NWAY-1:0] : ways_q;

  logic [1:0] scope_n, tid_n;
  logic       need_w, need_r, whole, bad_scope, armed_n;
  assign scope_n   = mode_n[18:17];
  assign tid_n     = mode_n[22:21];
  assign need_w    = scope_n == 2'd2 || tid_n == 2'd2;
  assign need_r    = scope_n == 2'd0;
  assign whole     = scope_n == 2'd1;
  assign bad_scope = wr_mode && scope_n == 2'd3;
  assign armed_n   = wr_mode ? !bad_scope : armed_q;

  logic trig, zero_sz, push, ovf_ev, fail_ev, pop;
  assign trig    = armed_n && (need_w ? wr_ways :
                               need_r ? wr_size :
                               (whole && wr_mode));
  assign zero_sz = trig && need_r && size_n == 32'd0;
  assign push    = trig && !zero_sz && cnt != FULL;
  assign ovf_ev  = trig && !zero_sz && cnt == FULL;
  assign fail_ev = bad_scope || zero_sz;

  logic [EW-1:0] entry, head;
  assign entry = {mode_n[14], mode_n[15], mode_n[22:21], mode_n[18:17],
                  mode_n[2:0], start_n, size_n, ways_n};
  assign head  = mem[rp];
  assign {ex_ctl, ex_notify, ex_tid, ex_scope, ex_op,
          ex_addr, ex_size, ex_ways} = head;

  assign ex_valid = cnt != '0 && !fly;
  assign pop      = ex_valid && ex_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      start_q <= '0;
      size_q  <= '0;
      ways_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      mode_q  <= mode_n;
      start_q <= start_n;
      size_q  <= size_n;
      ways_q  <= ways_n;
      armed_q <= trig ? 1'b0 : armed_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_f <= 1'b0;
      ovf_f  <= 1'b0;
    end else if (wr_mode || fail_ev || ovf_ev) begin
      fail_f <= fail_ev || (fail_f && !wr_mode);
      ovf_f  <= ovf_ev  || (ovf_f  && !wr_mode);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        mem[wp] <= entry;
        wp <= (wp == LAST) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  logic finish;
  assign finish = fly && ex_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fly        <= 1'b0;
      fly_notify <= 1'b0;
      end_f      <= 1'b0;
      err_f      <= 1'b0;
    end else begin
      if (pop) begin
        fly        <= 1'b1;
        fly_notify <= ex_notify;
      end else if (finish) begin
        fly <= 1'b0;
      end
      if (finish && fly_notify)     end_f <= 1'b1;
      else if (wr_qstat && wdata[2]) end_f <= 1'b0;
      if (finish && ex_err)          err_f <= 1'b1;
      else if (wr_qstat && wdata[1]) err_f <= 1'b0;
    end
  end

  logic prim_ok;
  assign prim_ok = wdata == 32'd0 || wdata == 32'd1 || wdata == 32'd2 ||
                   wdata == 32'd8 || wdata == 32'd9;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prim_busy <= 1'b0;
      pcode_q   <= '0;
    end else if (prim_busy) begin
      if (prim_done) prim_busy <= 1'b0;
    end else if (wr_prim && prim_ok) begin
      prim_busy <= 1'b1;
      pcode_q   <= wdata[3:0];
    end
  end

  assign prim_valid = prim_busy;
  assign prim_code  = pcode_q;

  logic [AW-1:0] rd_eff;
  logic          rd_go, rd_stall;
  logic [31:0]   rmux;
  assign rd_eff   = rd_hold ? rd_sel : addr;
  assign rd_go    = rd_en || rd_hold;
  assign rd_stall = rd_eff == A_PRIM && prim_busy;

  always_comb begin
    case (rd_eff)
      A_MODE:  rmux = mode_q;
      A_START: rmux = start_q;
      A_SIZE:  rmux = size_q;
      A_WAYS:  rmux = {{(32-NWAY){1'b0}}, ways_q};
      A_SETST: rmux = {30'd0, fail_f, ovf_f};
      A_QSTAT: rmux = {29'd0, end_f, err_f, cnt != '0 || fly};
      A_PRIM:  rmux = {28'd0, pcode_q};
      default: rmux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ack  <= 1'b0;
      rdata   <= '0;
      rd_hold <= 1'b0;
      rd_sel  <= '0;
    end else begin
      rd_ack <= 1'b0;
      if (rd_go && !rd_stall) begin
        rd_ack  <= 1'b1;
        rdata   <= rmux;
        rd_hold <= 1'b0;
      end else if (rd_go) begin
        rd_hold <= 1'b1;
        rd_sel  <= rd_eff;
      end
    end
  end

endmodule

module cmq_regfront_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ex_valid,
  input logic          ex_ready,
  input logic [2:0]    ex_op,
  input logic          ex_done,
  input logic [CW-1:0] cnt,
  input logic          ovf_f,
  input logic          end_f,
  input logic          rd_ack,
  input logic          rd_prim,
  input logic          prim_valid,
  input logic [3:0]    prim_code,
  input logic          prim_done
);

  p_queue_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_f) |-> $past(cnt) == CW'(DEPTH));

  p_offer_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid && !ex_ready |=> ex_valid && $stable(ex_op));

  p_end_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_f) |-> $past(ex_done));

  p_prim_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    prim_valid && !prim_done |=> prim_valid && $stable(prim_code));

  p_rd_barrier_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack && $past(rd_prim) |-> !$past(prim_valid));

endmodule

bind cmq_regfront cmq_regfront_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_ready(ex_ready),
  .ex_op(ex_op), .ex_done(ex_done), .cnt(cnt), .ovf_f(ovf_f),
  .end_f(end_f), .rd_ack(rd_ack), .rd_prim(rd_eff == A_PRIM),
  .prim_valid(prim_valid), .prim_code(prim_code), .prim_done(prim_done)
);

// File: tb/cmq_regfront_test.sv
`timescale 1ns/100ps
module cmq_regfront_test;

  localparam int DEPTH = 4;
  localparam int NWAY  = 8;
  localparam int AW    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rd_ack;
  logic ex_valid, ex_ready = 1'b0;
  logic [2:0] ex_op;
  logic [1:0] ex_scope, ex_tid;
  logic ex_notify, ex_ctl;
  logic [31:0] ex_addr, ex_size;
  logic [NWAY-1:0] ex_ways;
  logic ex_done = 1'b0, ex_err = 1'b0;
  logic prim_valid;
  logic [3:0] prim_code;
  logic prim_done = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cmq_regfront #(.DEPTH(DEPTH), .NWAY(NWAY), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_ack(rd_ack), .ex_valid(ex_valid),
    .ex_ready(ex_ready), .ex_op(ex_op), .ex_scope(ex_scope), .ex_tid(ex_tid),
    .ex_notify(ex_notify), .ex_ctl(ex_ctl), .ex_addr(ex_addr),
    .ex_size(ex_size), .ex_ways(ex_ways), .ex_done(ex_done), .ex_err(ex_err),
    .prim_valid(prim_valid), .prim_code(prim_code), .prim_done(prim_done)
  );

  // mode, start, size, ways, expected set status, expected queued
  localparam logic [130:0] VEC [7] = '{
    {32'h0000_C002, 32'h0000_1000, 32'h0000_0080, 32'h0000_0000, 2'd0, 1'b1},
    {32'h0002_8000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0055, 2'd0, 1'b1},
    {32'h0004_8000, 32'h0000_0000, 32'h0000_0000, 32'h0000_000F, 2'd0, 1'b1},
    {32'h0040_8003, 32'h0000_2000, 32'h0000_0100, 32'h0000_0030, 2'd0, 1'b1},
    {32'h0006_0001, 32'h0000_0040, 32'h0000_0080, 32'h0000_0001, 2'd2, 1'b0},
    {32'h0000_8001, 32'h0000_0040, 32'h0000_0000, 32'h0000_0001, 2'd2, 1'b0},
    {32'h0000_0001, 32'h0000_0040, 32'h0000_0080, 32'h0000_0001, 2'd0, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    while (!rd_ack) @(negedge clk);
    d = rdata;
  endtask

  task automatic accept();
    @(negedge clk); ex_ready = 1'b1;
    @(negedge clk); ex_ready = 1'b0;
  endtask

  task automatic finish_cmd(input logic e);
    @(negedge clk); ex_done = 1'b1; ex_err = e;
    @(negedge clk); ex_done = 1'b0; ex_err = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    check("R1 ex_valid", {31'd0, ex_valid}, 0);
    check("R1 prim_valid", {31'd0, prim_valid}, 0);
    rd(3'd0, d); check("R1 mode", d, 0);
    rd(3'd4, d); check("R1 set status", d, 0);
    rd(3'd5, d); check("R1 queue status", d, 0);
    rd(3'd7, d); check("R1 unused offset", d, 0);
    wr(3'd1, 32'h1234_5678);
    rd(3'd1, d); check("R2 start readback", d, 32'h1234_5678);

    for (int i = 0; i < 7; i++) begin
      logic [31:0] vs, vz, vw;
      logic [1:0] es;
      logic eq;
      {m, vs, vz, vw, es, eq} = VEC[i];
      wr(3'd5, 32'h6);
      wr(3'd0, m);
      wr(3'd1, vs);
      wr(3'd2, vz);
      wr(3'd3, vw);
      rd(3'd4, d); check($sformatf("R6 set status vec %0d", i), d, {30'd0, es});
      @(negedge clk);
      check($sformatf("R4 queued vec %0d", i), {31'd0, ex_valid}, {31'd0, eq});
      if (eq) begin
        check($sformatf("R3 op vec %0d", i), {29'd0, ex_op}, {29'd0, m[2:0]});
        check($sformatf("R3 scope vec %0d", i), {30'd0, ex_scope}, {30'd0, m[18:17]});
        check($sformatf("R3 tid vec %0d", i), {30'd0, ex_tid}, {30'd0, m[22:21]});
        check($sformatf("R3 notify ctl vec %0d", i), {30'd0, ex_notify, ex_ctl},
              {30'd0, m[15], m[14]});
        if (m[18:17] == 2'd0) begin
          check($sformatf("R4 addr vec %0d", i), ex_addr, vs);
          check($sformatf("R4 size vec %0d", i), ex_size, vz);
        end
        if (m[18:17] == 2'd2 || m[22:21] == 2'd2)
          check($sformatf("R5 ways vec %0d", i), {24'd0, ex_ways}, vw);
        rd(3'd5, d); check($sformatf("R9 busy vec %0d", i), d, 1);
        accept();
        check($sformatf("R8 single command vec %0d", i), {31'd0, ex_valid}, 0);
        finish_cmd(1'b0);
        rd(3'd5, d); check($sformatf("R10 end flag vec %0d", i), d, {29'd0, m[15], 2'd0});
      end else begin
        rd(3'd5, d); check($sformatf("R6 nothing queued vec %0d", i), d, 0);
      end
    end

    wr(3'd5, 32'h6);
    for (int k = 0; k < DEPTH; k++) begin
      wr(3'd0, 32'h0002_0000 | k);
      rd(3'd4, d); check($sformatf("R7 fill %0d", k), d, 0);
    end
    wr(3'd0, 32'h0002_0005);
    rd(3'd4, d); check("R7 overflow flag", d, 1);
    rd(3'd5, d); check("R9 busy while full", d, 1);
    wr(3'd0, 32'h0000_0000);
    rd(3'd4, d); check("R8 mode write clears flags", d, 0);
    for (int k = 0; k < DEPTH; k++) begin
      @(negedge clk);
      check($sformatf("R7 order %0d", k), {29'd0, ex_op}, k);
      accept();
      check($sformatf("R9 held during flight %0d", k), {31'd0, ex_valid}, 0);
      finish_cmd(1'b0);
    end
    @(negedge clk);
    check("R7 dropped command absent", {31'd0, ex_valid}, 0);
    rd(3'd5, d); check("R9 idle after drain", d, 0);

    wr(3'd0, 32'h0002_8000);
    accept();
    finish_cmd(1'b1);
    rd(3'd5, d); check("R11 end and error set", d, 6);
    wr(3'd5, 32'h0);
    rd(3'd5, d); check("R10 write zero keeps flags", d, 6);
    wr(3'd5, 32'h4);
    rd(3'd5, d); check("R10 end cleared alone", d, 2);
    wr(3'd5, 32'h2);
    rd(3'd5, d); check("R11 error cleared", d, 0);

    wr(3'd6, 32'h8);
    check("R11 drain raised", {27'd0, prim_valid, prim_code}, 32'h18);
    @(negedge clk);
    rd_en = 1'b1; addr = 3'd6;
    @(negedge clk);
    rd_en = 1'b0;
    repeat (3) begin
      check("R11 read withheld while pending", {31'd0, rd_ack}, 0);
      @(negedge clk);
    end
    prim_done = 1'b1;
    @(negedge clk);
    prim_done = 1'b0;
    check("R11 prim retired", {31'd0, prim_valid}, 0);
    while (!rd_ack) @(negedge clk);
    check("R11 barrier read data", rdata, 8);
    wr(3'd6, 32'h5);
    check("R11 bad code ignored", {31'd0, prim_valid}, 0);
    wr(3'd6, 32'h9);
    wr(3'd6, 32'h1);
    check("R11 busy write ignored", {27'd0, prim_valid, prim_code}, 32'h19);
    @(negedge clk); prim_done = 1'b1;
    @(negedge clk); prim_done = 1'b0;
    rd(3'd6, d); check("R11 plain read when idle", d, 9);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule